// File: doc/BRIEF.md
# Lockstep Multi-Lane Single-Wire LED Encoder

This block drives up to eight single-wire LED strips at the same time. A source hands it one word per step, and each word holds one pixel byte for every lane. The block turns each byte into serial bit cells. A cell is five equal time slices. At 200 MHz, one slice is 250 ns by default. Every lane shares the same slice timer and cell counter, so all strips begin each bit in the same slice.

Within a cell, the first slice is high. The next two slices carry the data bit. The last two slices are low. A '0' therefore makes a short high pulse and a '1' makes a long one. Each byte is sent most significant bit first.

After the last byte of a frame has been fully emitted, the block holds every line low for a reset interval, measured by a stop countdown. Only then does it accept the next frame. If the next byte is missing when a byte ends, the block does not hold the line level. It pulls all lines low, abandons the frame, runs the reset interval, and raises a sticky underrun flag. A per-lane enable mask keeps unused outputs low.

Top module: `led_lane_encoder`

## Requirements
- R1: Every bit cell lasts 5 slices of SLICE_DIV clock cycles each. A '0' is high for exactly 1 slice and then low for 4 slices. A '1' is high for exactly 3 slices and then low for 2 slices. Within a frame, cell starts on a lane are 5 slices apart.
- R2: The byte for lane n is taken from bits [8n+7:8n] of `s_data`. It is sent most significant bit first.
- R3: Outputs change only at slice boundaries. All enabled lanes go high together at the start of every cell.
- R4: A word is accepted on a clock edge where `s_valid` and `s_ready` are both 1. One word can wait in a single holding register. `s_ready` is 0 while that register is full, during the reset interval, and once all FRAME_BYTES words of the current frame have been taken.
- R5: A frame is FRAME_BYTES words. After its last cell has completed in full, all lines stay low for at least RESET_SLICES slices before the next frame's first high slice.
- R6: After reset, `led_out` is all 0, `underrun` is 0 and `s_ready` is 1. Lines are low whenever no frame is being sent.
- R7: If no word is buffered when a byte ends before the frame is complete, all lines go low in the next slice. The frame is dropped and the reset interval follows. `underrun` is set and stays 1 until reset.
- R8: A lane whose `lane_en` bit is 0 stays low for the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_en | input | LANES | Per-lane output enable mask |
| s_valid | input | 1 | Source offers a pixel word |
| s_ready | output | 1 | Block can take a pixel word |
| s_data | input | 8*LANES | One pixel byte per lane |
| led_out | output | LANES | Registered serial line per strip |
| underrun | output | 1 | Sticky starvation flag |

## Verification
Each slice value is registered on the slice tick, so a level appears one clock after the tick and holds for SLICE_DIV cycles. The bench samples on the falling clock edge and measures pulse widths and gaps in whole cycles, never at a fixed edge. A frame's bits are complete about 40·FRAME_BYTES slices after its first word is taken, and an underrun appears 40 slices after the last byte starts. The directed checks therefore wait a margin past those points before reading `underrun`, `s_ready` or the decoded lane streams. The reset gap is measured from the last falling line to the next rising one.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_STOP
  } enc_state_e;

  typedef enum logic [1:0] {
    DRV_LOW,
    DRV_ALL,
    DRV_BIT
  } drive_e;

  localparam int unsigned CELL_SLICES = 5;

  // slice 0 high, slices 1-2 carry the bit, slices 3-4 low
  function automatic drive_e slice_drive(input logic [2:0] slc);
    if (slc == 3'd0) return DRV_ALL;
    else if (slc == 3'd1 || slc == 3'd2) return DRV_BIT;
    else return DRV_LOW;
  endfunction

endpackage

// File: rtl/led_slice_timer.sv
module led_slice_timer #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/led_input_stage.sv
module led_input_stage #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         allow,
  input  logic         take,
  input  logic         s_valid,
  input  logic [W-1:0] s_data,
  output logic         s_ready,
  output logic         hold_valid,
  output logic [W-1:0] hold_data
);
  assign s_ready = allow && !hold_valid;

  always_ff @(posedge clk) begin
    if (rst) hold_valid <= 1'b0;
    else if (s_valid && s_ready) hold_valid <= 1'b1;
    else if (take) hold_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (s_valid && s_ready) hold_data <= s_data;
  end
endmodule

// File: rtl/led_lane_shifter.sv
module led_lane_shifter #(
  parameter int unsigned LANES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               shift,
  input  logic [LANES*8-1:0] load_data,
  output logic [LANES-1:0]   msb
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else if (load) sr <= load_data[g*8 +: 8];
      else if (shift) sr <= {sr[6:0], 1'b0};
    end
    assign msb[g] = sr[7];
  end
endmodule

// File: rtl/led_lane_encoder.sv
module led_lane_encoder
  import led_enc_pkg::*;
#(
  parameter int unsigned LANES        = 8,
  parameter int unsigned SLICE_DIV    = 50,
  parameter int unsigned FRAME_BYTES  = 1440,
  parameter int unsigned RESET_SLICES = 200
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES-1:0]   lane_en,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [LANES*8-1:0] s_data,
  output logic [LANES-1:0]   led_out,
  output logic               underrun
);
  localparam int unsigned WW  = LANES * 8;
  localparam int unsigned BCW = $clog2(FRAME_BYTES + 1);
  localparam int unsigned RCW = (RESET_SLICES > 1) ? $clog2(RESET_SLICES) : 1;
  localparam logic [2:0]  LAST_SLC = 3'(CELL_SLICES - 1);

  enc_state_e       state;
  logic [2:0]       slc;
  logic [2:0]       bitn;
  logic [BCW-1:0]   byte_cnt;
  logic [RCW-1:0]   stop_cnt;

  logic             slice_tick;
  logic             hold_valid;
  logic [WW-1:0]    hold_data;
  logic [LANES-1:0] lane_msb;

  logic cell_end, byte_end, frame_done;
  logic allow, take, shift;
  logic [2:0] slc_nx;

  led_slice_timer #(.DIV(SLICE_DIV)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (slice_tick)
  );

  always_comb begin
    cell_end   = (slc == LAST_SLC);
    byte_end   = cell_end && (bitn == 3'd7);
    frame_done = (byte_cnt == BCW'(FRAME_BYTES));
    allow      = (state == ST_IDLE) || (state == ST_DATA && !frame_done);
    take       = slice_tick && hold_valid &&
                 ((state == ST_IDLE) ||
                  (state == ST_DATA && byte_end && !frame_done));
    shift      = slice_tick && (state == ST_DATA) && cell_end && (bitn != 3'd7);
    slc_nx     = slc + 3'd1;
  end

  led_input_stage #(.W(WW)) u_in (
    .clk        (clk),
    .rst        (rst),
    .allow      (allow),
    .take       (take),
    .s_valid    (s_valid),
    .s_data     (s_data),
    .s_ready    (s_ready),
    .hold_valid (hold_valid),
    .hold_data  (hold_data)
  );

  led_lane_shifter #(.LANES(LANES)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (take),
    .shift     (shift),
    .load_data (hold_data),
    .msb       (lane_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      slc      <= '0;
      bitn     <= '0;
      byte_cnt <= '0;
      stop_cnt <= '0;
      led_out  <= '0;
      underrun <= 1'b0;
    end else if (slice_tick) begin
      unique case (state)
        ST_IDLE: begin
          if (hold_valid) begin
            state    <= ST_DATA;
            slc      <= '0;
            bitn     <= '0;
            byte_cnt <= BCW'(1);
            led_out  <= lane_en;
          end else begin
            led_out  <= '0;
          end
        end
        ST_DATA: begin
          if (!cell_end) begin
            slc <= slc_nx;
            unique case (slice_drive(slc_nx))
              DRV_ALL: led_out <= lane_en;
              DRV_BIT: led_out <= lane_en & lane_msb;
              default: led_out <= '0;
            endcase
          end else begin
            slc <= '0;
            if (!byte_end) begin
              bitn    <= bitn + 3'd1;
              led_out <= lane_en;
            end else if (frame_done) begin
              state    <= ST_STOP;
              stop_cnt <= RCW'(RESET_SLICES - 1);
              led_out  <= '0;
            end else if (hold_valid) begin
              bitn     <= '0;
              byte_cnt <= byte_cnt + 1'b1;
              led_out  <= lane_en;
            end else begin
              underrun <= 1'b1;
              state    <= ST_STOP;
              stop_cnt <= RCW'(RESET_SLICES - 1);
              led_out  <= '0;
            end
          end
        end
        ST_STOP: begin
          led_out <= '0;
          if (stop_cnt == '0) state <= ST_IDLE;
          else stop_cnt <= stop_cnt - 1'b1;
        end
        default: begin
          state   <= ST_IDLE;
          led_out <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/led_lane_encoder_chk.sv
module led_lane_encoder_chk
  import led_enc_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             slice_tick,
  input logic [LANES-1:0] lane_en,
  input logic [LANES-1:0] led_out,
  input logic             underrun,
  input logic             s_ready,
  input enc_state_e       state
);
  AST_OUT_ON_SLICE: assert property (@(posedge clk) disable iff (rst)
    !$past(slice_tick) |-> $stable(led_out)); // R3

  AST_MASKED_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(slice_tick) |-> ((led_out & ~$past(lane_en)) == '0)); // R8

  AST_NO_TAKE_IN_STOP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP) |-> !s_ready); // R4

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (led_out == '0)); // R6

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun); // R7

  AST_UNDERRUN_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> (led_out == '0 && state == ST_STOP)); // R7
endmodule

bind led_lane_encoder led_lane_encoder_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slice_tick (slice_tick),
  .lane_en    (lane_en),
  .led_out    (led_out),
  .underrun   (underrun),
  .s_ready    (s_ready),
  .state      (state)
);

// File: tb/led_lane_encoder_test.sv
module led_lane_encoder_test;
  localparam int LN = 8;
  localparam int SD = 2;
  localparam int FB = 3;
  localparam int RS = 6;
  localparam int NV = 4;

  localparam logic [63:0] VW [NV][FB] = '{
    '{64'h0123456789ABCDEF, 64'hFF00AA550FF0817E, 64'h8001C33C6699E718},
    '{64'h00FF00FF55AA55AA, 64'h1122334455667788, 64'hFEDCBA9876543210},
    '{64'h8000000000000001, 64'h7F00000000000080, 64'hA5A5A5A5A5A5A5A5},
    '{64'h0000000000000000, 64'hFFFFFFFFFFFFFFFF, 64'h0000000000000000}
  };
  localparam logic [7:0] VEN [NV] = '{8'hFF, 8'h5A, 8'h81, 8'hFF};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LN-1:0] lane_en = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [LN*8-1:0] s_data = '0;
  logic [LN-1:0] led_out;
  logic underrun;

  always #2.5 clk = ~clk;

  led_lane_encoder #(
    .LANES(LN), .SLICE_DIV(SD), .FRAME_BYTES(FB), .RESET_SLICES(RS)
  ) uut (
    .clk(clk), .rst(rst), .lane_en(lane_en), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .led_out(led_out), .underrun(underrun)
  );

  int n_chk = 0, n_err = 0;
  int m_chk = 0, m_err = 0;
  int wd_err = 0;

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mchk(input string req, input bit ok, input longint act, input longint exp);
    m_chk++;
    if (!ok) begin
      m_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // line monitor: decodes pulse widths into bits per lane
  int cyc = 0;
  logic [LN-1:0] prev = '0;
  int hi_len [LN];
  int last_rise [LN];
  logic cap [LN][512];
  int cnt [LN];
  int lo_len = 0;
  int last_gap = 0;

  initial begin
    for (int l = 0; l < LN; l++) begin
      hi_len[l] = 0; last_rise[l] = -1000; cnt[l] = 0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    for (int l = 0; l < LN; l++) begin
      if (led_out[l] && !prev[l]) begin
        if (cyc - last_rise[l] < 10*SD)
          mchk("R1 cell period", (cyc - last_rise[l]) == 5*SD, cyc - last_rise[l], 5*SD);
        last_rise[l] = cyc;
        hi_len[l] = 1;
      end else if (led_out[l]) begin
        hi_len[l]++;
      end else if (prev[l]) begin
        mchk("R1 high width", hi_len[l] == SD || hi_len[l] == 3*SD, hi_len[l], SD);
        if (cnt[l] < 512) begin
          cap[l][cnt[l]] = (hi_len[l] == 3*SD);
          cnt[l]++;
        end
      end
    end
    if ((led_out & ~prev) != '0)
      mchk("R3 lockstep start", led_out == lane_en, led_out, lane_en);
    if (|led_out) begin
      if (prev == '0 && lo_len > 4*SD) last_gap = lo_len;
      lo_len = 0;
    end else begin
      lo_len++;
    end
    prev = led_out;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk + m_chk + wd_err, n_err + m_err + wd_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    wd_err = 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  task automatic send(input logic [63:0] d);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = d;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1 s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int base [LN];

  initial begin
    logic [23:0] got, want;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R6 reset lines", led_out == '0, led_out, 0);
    chk("R6 reset flag", underrun == 1'b0, underrun, 0);
    chk("R6 reset ready", s_ready == 1'b1, s_ready, 1);

    // table walk: frame data, enable mask, decoded streams (R1 R2 R8)
    for (int v = 0; v < NV; v++) begin
      lane_en = VEN[v];
      for (int l = 0; l < LN; l++) base[l] = cnt[l];
      for (int w = 0; w < FB; w++) send(VW[v][w]);
      idle(300);
      for (int l = 0; l < LN; l++) begin
        want = '0;
        got  = '0;
        for (int w = 0; w < FB; w++)
          for (int b = 0; b < 8; b++)
            want[23 - (w*8 + b)] = VW[v][w][l*8 + 7 - b];
        if (VEN[v][l]) begin
          for (int i = 0; i < 24; i++)
            if (base[l] + i < 512) got[23 - i] = cap[l][base[l] + i];
          chk("R2 lane bits", (cnt[l] - base[l]) == 24 && got == want, got, want);
        end else begin
          chk("R8 disabled lane", (cnt[l] - base[l]) == 0, cnt[l] - base[l], 0);
        end
      end
      chk("R6 idle low", led_out == '0, led_out, 0);
    end
    chk("R7 no flag on full frames", underrun == 1'b0, underrun, 0);

    // R4 back-pressure and R5 reset gap between back-to-back frames
    lane_en = 8'hFF;
    send(64'h0102030405060708);
    send(64'h1112131415161718);
    send(64'h8181818181818181);
    idle(100);
    chk("R4 ready low after full frame", s_ready == 1'b0, s_ready, 0);
    send(64'hF0F0F0F0F0F0F0F0);
    send(64'h0F0F0F0F0F0F0F0F);
    send(64'h3333333333333333);
    idle(300);
    chk("R5 reset gap low bound", last_gap >= RS*SD, last_gap, RS*SD);
    chk("R5 reset gap high bound", last_gap <= (RS+5)*SD, last_gap, (RS+5)*SD);

    // R7 underrun: one word of a three-word frame
    lane_en = 8'h0F;
    for (int l = 0; l < LN; l++) base[l] = cnt[l];
    send(64'hC3C3C3C3C3C3C3C3);
    idle(90);
    chk("R7 flag set", underrun == 1'b1, underrun, 1);
    chk("R7 lines low", led_out == '0, led_out, 0);
    chk("R7 partial byte only", (cnt[0] - base[0]) == 8, cnt[0] - base[0], 8);
    idle(40);
    chk("R7 flag sticky", underrun == 1'b1, underrun, 1);
    chk("R4 ready after stop", s_ready == 1'b1, s_ready, 1);
    chk("R8 masked lane silent", (cnt[7] - base[7]) == 0, cnt[7] - base[7], 0);

    @(posedge clk);
    #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R6 reset clears flag", underrun == 1'b0, underrun, 0);
    chk("R6 reset lines low", led_out == '0, led_out, 0);

    summary();
    $finish;
  end
endmodule